// File: doc/BRIEF.md
# Configuration word stream packet processor

The block takes a stream of 32-bit words that configures a programmable device. Until it has seen the synchronisation word 0xAA995566 it throws every word away, padding words such as 0xFFFFFFFF included. From then on it reads packet headers. Each header names a target register, an operation and a word count. The payload words that follow are stored in the command, frame length, options, device identifier, mask and frame address registers, or are streamed out as frame data.

Frame data reaches the output only after a write-configuration command has been accepted. Each forwarded word carries the frame address that was current when it arrived. After every complete frame of (frame length + 1) words the block emits a frame-done pulse and steps the frame address by one.

An identifier that does not match the expected value raises a sticky error and sends the block back to hunting for the sync word. Frame data that arrives before configuration writes are enabled is dropped and raises a second sticky error.

Top module: `cfg_pkt_proc`

## Requirements
- R1: After reset every register output, the frame-data outputs, both error flags and synced_o are 0, and word_ready_o is 1.
- R2: Before sync, accepted words other than 0xAA995566 change no output, even when they form valid headers and payloads. A word is accepted only when word_valid_i is 1. The cycle after the sync word is accepted, synced_o is 1.
- R3: A first-format header is a word with bits 31:29 = 001 and bits 28:27 = 10 (write). Bits 17:13 hold the register address and bits 10:0 the word count. The addresses are: command 4, frame length 11, options 9, identifier 14, mask 6, frame address 1. Each payload word is visible on its register output the cycle after it is accepted.
- R4: A second-format header is a word with bits 31:29 = 010 and bits 28:27 = 10. Bits 26:0 give the word count, and the payload goes to the register named by the last first-format header. A first-format header with a count of 0 (for example frame data input, address 2) loads no payload.
- R5: Writing command value 0x1 sets wcfg_en_o. Other command values, for example 0x7 and 0x9, are only stored on cmd_o.
- R6: A frame-data word accepted while wcfg_en_o is 1 appears on fdata_o one cycle later. In that cycle fdata_valid_o is 1, and fdata_far_o holds the frame address that was in effect when the word was accepted.
- R7: A frame holds flen_o + 1 words; a length of 0x24 gives 37 words. On the cycle the last word of a frame is forwarded, frame_done_o pulses for one cycle and far_o has already increased by one.
- R8: Writing the frame address register sets far_o and restarts the word position within the frame.
- R9: Frame-data words accepted while wcfg_en_o is 0 are not forwarded, and err_wcfg_o is set and stays set until reset.
- R10: An identifier payload that differs from parameter EXP_ID sets err_id_o, which stays set until reset. The same word clears synced_o. Headers are then ignored until the next sync word.
- R11: Once the payload count is used up, the block decodes headers again. Words that are not write headers of either format are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 32 | Configuration stream word |
| word_valid_i | input | 1 | word_i is valid this cycle |
| word_ready_o | output | 1 | Always 1: a word is taken every cycle |
| synced_o | output | 1 | Sync word seen, headers are being decoded |
| cmd_o | output | 32 | Command register |
| flen_o | output | 32 | Frame length register (words minus one) |
| opt_o | output | 32 | Options register |
| id_o | output | 32 | Last identifier written |
| mask_o | output | 32 | Mask register |
| far_o | output | 32 | Current frame address |
| wcfg_en_o | output | 1 | Configuration writes enabled |
| fdata_o | output | 32 | Forwarded frame-data word |
| fdata_valid_o | output | 1 | fdata_o is valid |
| fdata_far_o | output | 32 | Frame address of the forwarded word |
| frame_done_o | output | 1 | One-cycle pulse when a frame completes |
| err_wcfg_o | output | 1 | Sticky: frame data dropped, writes not enabled |
| err_id_o | output | 1 | Sticky: identifier mismatch |

## Verification
Every result is due one clock edge after the word that causes it is accepted. This covers register outputs, synced_o, wcfg_en_o, the forwarded word, frame_done_o, the far_o step and both error flags. The bench drives each word at the falling edge and holds word_valid_i for exactly one rising edge. It samples 1 ns after that edge, so every check sees the single register stage and nothing earlier. Checks that a word was ignored also sample one cycle after the idle or ignored word, at the outputs that word could have changed.

// File: rtl/cfg_pkt_pkg.sv
package cfg_pkt_pkg;
  localparam int WORD_W = 32;
  localparam int RA_W   = 5;
  localparam int CNT_W  = 27;
  localparam logic [WORD_W-1:0] SYNC_WORD = 32'hAA995566;
  localparam logic [WORD_W-1:0] CMD_WCFG  = 32'h00000001;

  localparam logic [RA_W-1:0] RA_FAR  = 5'd1;
  localparam logic [RA_W-1:0] RA_FDRI = 5'd2;
  localparam logic [RA_W-1:0] RA_CMD  = 5'd4;
  localparam logic [RA_W-1:0] RA_MASK = 5'd6;
  localparam logic [RA_W-1:0] RA_OPT  = 5'd9;
  localparam logic [RA_W-1:0] RA_FLEN = 5'd11;
  localparam logic [RA_W-1:0] RA_ID   = 5'd14;

  typedef enum logic [1:0] {ST_HUNT, ST_HDR, ST_PAY} state_e;

  typedef struct packed {
    logic             t1;
    logic             t2;
    logic             wr;
    logic [RA_W-1:0]  ra;
    logic [CNT_W-1:0] cnt;
  } hdr_t;
endpackage

// File: rtl/cfg_hdr_decode.sv
module cfg_hdr_decode
  import cfg_pkt_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output hdr_t              hdr_o
);
  always_comb begin
    hdr_o.t1  = (word_i[31:29] == 3'b001);
    hdr_o.t2  = (word_i[31:29] == 3'b010);
    hdr_o.wr  = (word_i[28:27] == 2'b10);
    hdr_o.ra  = word_i[17:13];
    hdr_o.cnt = hdr_o.t2 ? word_i[CNT_W-1:0] : {{(CNT_W-11){1'b0}}, word_i[10:0]};
  end
endmodule

// File: rtl/cfg_frame_ctr.sv
module cfg_frame_ctr #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] addr_i,
  input  logic          step_i,
  input  logic [DW-1:0] flen_i,
  output logic [DW-1:0] far_o,
  output logic          done_o
);
  logic [DW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      far_o  <= '0;
      idx_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        far_o <= addr_i;
        idx_q <= '0;
      end else if (step_i) begin
        if (idx_q == flen_i) begin
          idx_q  <= '0;
          far_o  <= far_o + 1'b1;
          done_o <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_pkt_proc.sv
module cfg_pkt_proc
  import cfg_pkt_pkg::*;
#(
  parameter logic [WORD_W-1:0] EXP_ID = 32'h0140D093
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic              synced_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic [WORD_W-1:0] flen_o,
  output logic [WORD_W-1:0] opt_o,
  output logic [WORD_W-1:0] id_o,
  output logic [WORD_W-1:0] mask_o,
  output logic [WORD_W-1:0] far_o,
  output logic              wcfg_en_o,
  output logic [WORD_W-1:0] fdata_o,
  output logic              fdata_valid_o,
  output logic [WORD_W-1:0] fdata_far_o,
  output logic              frame_done_o,
  output logic              err_wcfg_o,
  output logic              err_id_o
);
  state_e           state_q;
  logic [RA_W-1:0]  tgt_q;
  logic [CNT_W-1:0] cnt_q;
  hdr_t             hdr;
  logic             pay_acc, far_load, fd_step;

  cfg_hdr_decode u_dec (.word_i(word_i), .hdr_o(hdr));

  assign word_ready_o = 1'b1;
  assign synced_o     = (state_q != ST_HUNT);
  assign pay_acc      = word_valid_i && (state_q == ST_PAY);
  assign far_load     = pay_acc && (tgt_q == RA_FAR);
  assign fd_step      = pay_acc && (tgt_q == RA_FDRI) && wcfg_en_o;

  cfg_frame_ctr #(.DW(WORD_W)) u_fctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (far_load),
    .addr_i (word_i),
    .step_i (fd_step),
    .flen_i (flen_o),
    .far_o  (far_o),
    .done_o (frame_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_HUNT;
      tgt_q         <= '0;
      cnt_q         <= '0;
      cmd_o         <= '0;
      flen_o        <= '0;
      opt_o         <= '0;
      id_o          <= '0;
      mask_o        <= '0;
      wcfg_en_o     <= 1'b0;
      fdata_o       <= '0;
      fdata_valid_o <= 1'b0;
      fdata_far_o   <= '0;
      err_wcfg_o    <= 1'b0;
      err_id_o      <= 1'b0;
    end else begin
      fdata_valid_o <= 1'b0;
      if (word_valid_i) begin
        unique case (state_q)
          ST_HUNT: if (word_i == SYNC_WORD) state_q <= ST_HDR;
          ST_HDR: begin
            if (hdr.t1 && hdr.wr) begin
              tgt_q <= hdr.ra;
              if (hdr.cnt != '0) begin
                cnt_q   <= hdr.cnt;
                state_q <= ST_PAY;
              end
            end else if (hdr.t2 && hdr.wr && hdr.cnt != '0) begin
              cnt_q   <= hdr.cnt;
              state_q <= ST_PAY;
            end
          end
          ST_PAY: begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) state_q <= ST_HDR;
            case (tgt_q)
              RA_CMD: begin
                cmd_o <= word_i;
                if (word_i == CMD_WCFG) wcfg_en_o <= 1'b1;
              end
              RA_FLEN: flen_o <= word_i;
              RA_OPT:  opt_o  <= word_i;
              RA_MASK: mask_o <= word_i;
              RA_ID: begin
                id_o <= word_i;
                if (word_i != EXP_ID) begin
                  err_id_o <= 1'b1;
                  state_q  <= ST_HUNT;
                end
              end
              RA_FDRI: begin
                if (wcfg_en_o) begin
                  fdata_o       <= word_i;
                  fdata_valid_o <= 1'b1;
                  fdata_far_o   <= far_o;
                end else begin
                  err_wcfg_o <= 1'b1;
                end
              end
              default: ;
            endcase
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_pkt_chk.sv
module cfg_pkt_chk
  import cfg_pkt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              word_valid_i,
  input logic              synced_o,
  input logic [WORD_W-1:0] far_o,
  input logic              wcfg_en_o,
  input logic              fdata_valid_o,
  input logic [WORD_W-1:0] fdata_far_o,
  input logic              frame_done_o,
  input logic              err_wcfg_o,
  input logic              err_id_o
);
  assert_presync_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !synced_o |-> !fdata_valid_o);
  assert_fdata_from_word_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fdata_valid_o) |-> $past(word_valid_i));
  assert_frame_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (far_o == fdata_far_o + 1'b1) && fdata_valid_o);
  assert_fdata_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fdata_valid_o |-> wcfg_en_o);
  assert_wcfg_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_wcfg_o |=> err_wcfg_o);
  assert_wcfg_err_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_wcfg_o) |-> !wcfg_en_o);
  assert_id_err_unsync_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_id_o) |-> !synced_o);
  assert_id_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_id_o |=> err_id_o);
endmodule

bind cfg_pkt_proc cfg_pkt_chk u_chk (.*);

// File: tb/tb_cfg_pkt_proc.sv
module tb_cfg_pkt_proc;
  localparam logic [31:0] EXP = 32'h0140D093;
  localparam int NV = 21;
  // {exp_synced, exp_wcfg, word}
  localparam logic [33:0] VEC [NV] = '{
    {2'b00, 32'hFFFFFFFF}, {2'b00, 32'h12345678}, {2'b10, 32'hAA995566},
    {2'b10, 32'h30008001}, {2'b10, 32'h00000007}, {2'b10, 32'h30016001},
    {2'b10, 32'h00000002}, {2'b10, 32'h30012001}, {2'b10, 32'h00003FE5},
    {2'b10, 32'h3001C001}, {2'b10, EXP},          {2'b10, 32'h3000C001},
    {2'b10, 32'h00000000}, {2'b10, 32'h30008001}, {2'b10, 32'h00000009},
    {2'b10, 32'h30002001}, {2'b10, 32'h00000005}, {2'b10, 32'h30008001},
    {2'b11, 32'h00000001}, {2'b11, 32'h30004000}, {2'b11, 32'h50000006}
  };

  logic clk_i = 0, rst_ni = 0, word_valid_i = 0;
  logic [31:0] word_i = '0;
  logic word_ready_o, synced_o, wcfg_en_o, fdata_valid_o, frame_done_o, err_wcfg_o, err_id_o;
  logic [31:0] cmd_o, flen_o, opt_o, id_o, mask_o, far_o, fdata_o, fdata_far_o;
  int errs = 0, checks = 0, dones = 0;

  always #2 clk_i = ~clk_i;

  cfg_pkt_proc #(.EXP_ID(EXP)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk_i);
    word_i = w;
    word_valid_i = 1'b1;
    @(posedge clk_i);
    #1 word_valid_i = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    word_valid_i = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle();
  endtask

  initial begin
    #(4 * 100000);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 synced", {31'b0, synced_o}, 0);
    chk("R1 ready", {31'b0, word_ready_o}, 1);
    chk("R1 regs", cmd_o | flen_o | opt_o | id_o | mask_o | far_o, 0);
    chk("R1 flags", {26'b0, wcfg_en_o, fdata_valid_o, frame_done_o, err_wcfg_o, err_id_o, 1'b0}, 0);
    // R2 headers before sync and sync with valid low are ignored
    send(32'h30008001);
    send(32'h00000007);
    chk("R2 presync cmd", cmd_o, 0);
    @(negedge clk_i);
    word_i = 32'hAA995566;
    idle();
    chk("R2 valid low", {31'b0, synced_o}, 0);

    // table walk: R2 R3 R4 R5 R8
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][31:0]);
      chk($sformatf("R2 synced v%0d", i), {31'b0, synced_o}, {31'b0, VEC[i][33]});
      chk($sformatf("R5 wcfg v%0d", i), {31'b0, wcfg_en_o}, {31'b0, VEC[i][32]});
    end
    chk("R5 cmd", cmd_o, 1);
    chk("R3 flen", flen_o, 2);
    chk("R3 opt", opt_o, 32'h3FE5);
    chk("R3 id", id_o, EXP);
    chk("R3 mask", mask_o, 0);
    chk("R8 far", far_o, 5);

    // R4 R6 R7: six words, two frames of three
    for (int i = 0; i < 6; i++) begin
      send(32'hD0000000 + i);
      chk($sformatf("R6 valid w%0d", i), {31'b0, fdata_valid_o}, 1);
      chk($sformatf("R6 data w%0d", i), fdata_o, 32'hD0000000 + i);
      chk($sformatf("R6 far w%0d", i), fdata_far_o, (i < 3) ? 5 : 6);
      chk($sformatf("R7 done w%0d", i), {31'b0, frame_done_o}, (i == 2 || i == 5) ? 1 : 0);
    end
    chk("R7 far after", far_o, 7);
    idle();
    chk("R7 done pulse", {31'b0, frame_done_o}, 0);
    // R11 count used up: non-header ignored, header decoded
    send(32'hDEADBEEF);
    chk("R11 no fdata", {31'b0, fdata_valid_o}, 0);
    chk("R11 far kept", far_o, 7);
    chk("R11 cmd kept", cmd_o, 1);
    send(32'h30008001);
    send(32'h00000009);
    chk("R11 cmd hdr", cmd_o, 9);
    chk("R5 wcfg kept", {31'b0, wcfg_en_o}, 1);

    // R9 frame data without write enable
    do_reset();
    send(32'hAA995566);
    send(32'h30004000);
    send(32'h50000002);
    send(32'h11111111);
    chk("R9 dropped", {31'b0, fdata_valid_o}, 0);
    chk("R9 err", {31'b0, err_wcfg_o}, 1);
    send(32'h22222222);
    idle();
    chk("R9 sticky", {31'b0, err_wcfg_o}, 1);
    chk("R9 far", far_o, 0);

    // R10 identifier mismatch
    do_reset();
    send(32'hAA995566);
    send(32'h3001C001);
    send(32'h00000BAD);
    chk("R10 err", {31'b0, err_id_o}, 1);
    chk("R10 unsync", {31'b0, synced_o}, 0);
    send(32'h30008001);
    send(32'h00000007);
    chk("R10 ignored", cmd_o, 0);
    send(32'hAA995566);
    chk("R10 resync", {31'b0, synced_o}, 1);
    chk("R10 sticky", {31'b0, err_id_o}, 1);

    // R7 R8 37-word frame
    do_reset();
    send(32'hAA995566);
    send(32'h30016001);
    send(32'h00000024);
    send(32'h30008001);
    send(32'h00000001);
    send(32'h30002001);
    send(32'h00000000);
    send(32'h30004000);
    send(32'h50000025);
    dones = 0;
    for (int i = 0; i < 37; i++) begin
      send(32'hC0000000 + i);
      if (frame_done_o) dones++;
      if (i == 35) chk("R7 no early done", {31'b0, frame_done_o}, 0);
    end
    chk("R7 done last", {31'b0, frame_done_o}, 1);
    chk("R7 one done", dones, 1);
    chk("R7 far 37", far_o, 1);
    chk("R8 far from zero", fdata_far_o, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule